// File: doc/BRIEF.md
# Standby Oscillator Period Measurement Controller

This block measures how long one period of a slow standby clock lasts in cycles of the fast main clock. It holds a small control register that the CPU writes and reads. A 3-bit trim code in that register goes to the RC oscillator and sets its frequency. A test bit drives a select output, which switches the timer input over to the block's gate signal. A request bit starts a measurement.

The standby clock is treated as a data signal. It passes through a two-flop synchronizer, and its rising edges are detected in the main clock domain. After software sets the request bit, the gate goes high on the next detected standby rising edge. It goes low on the following one, so it stays high for exactly one standby period. An external timer counts main clocks while the gate is high.

When the gate falls, a sticky ready flag is set. Software cannot clear that flag while the request bit is still stored as set. To take a new measurement, software must clear the request bit and then set it again.

Top module: `osc_meas_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00, fc_trim is 000 (44 kHz), and gate and tmr_sel are low.
- R2: A write stores trim code bits 2:0 on fc_trim. The code maps to a frequency of 44 − 4·code kHz, so code 011 gives 32 kHz and code 111 gives 16 kHz. The trim code, the test bit (bit 3) and the request bit (bit 4) all read back at the same positions.
- R3: tmr_sel equals the stored test bit, which is bit 3.
- R4: Setting the request bit (bit 4) produces one high pulse on gate. The pulse starts on the first synchronized standby rising edge and lasts one standby period in main clock cycles.
- R5: The ready bit (bit 7) becomes 1 in the cycle in which gate falls.
- R6: While the stored request bit is 1, a write with bit 7 = 0 leaves ready at 1.
- R7: Once the stored request bit is 0, a write with bit 7 = 0 clears ready. A software write of 1 to bit 7 never sets ready.
- R8: Bits 6 and 5 of rd_data always read 0, whatever is written to them.
- R9: Each 0→1 transition of the request bit gives at most one pulse. Keeping the bit set gives no further pulse, and clearing it and setting it again gives a new pulse.
- R10: If the request bit is cleared before the gate has risen, no pulse is produced and ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sby_clk | input | 1 | Standby clock, sampled as data |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| gate | output | 1 | Measurement gate, high for one standby period |
| tmr_sel | output | 1 | Selects gate as the timer input |
| fc_trim | output | 3 | Oscillator frequency trim code |

## Verification
The bench measures the gate width against a standby clock of exactly 40 main cycles. A design that opened or closed the gate on the wrong edge, or used an unsynchronized edge, would report a width of 20 or 41. The bench clears the request bit while ready is set and checks that ready survives that write; a design that looked at the newly written request bit would drop ready too early. The bench also keeps the request bit set after a pulse, and it clears the bit before the first standby edge. A design that re-armed on the level of the request bit would pulse again in the first case. A design without a cancel path would still fire a pulse in the second case.

// File: rtl/osc_meas_pkg.sv
package osc_meas_pkg;
  localparam int REG_W     = 8;
  localparam int FC_W      = 3;
  localparam int BIT_TEST  = 3;
  localparam int BIT_COUNT = 4;
  localparam int BIT_READY = 7;

  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_WAIT = 2'd1,
    GS_HIGH = 2'd2,
    GS_DONE = 2'd3
  } gate_st_e;

  // Nominal oscillator frequency in kHz for a trim code: highest at code 0.
  function automatic int unsigned fc_to_khz(input logic [FC_W-1:0] code);
    return 32'd44 - 32'd4 * 32'(code);
  endfunction
endpackage

// File: rtl/sby_edge_sync.sv
module sby_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/gate_gen.sv
module gate_gen
  import osc_meas_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic count_req,
  input  logic sby_rise,
  output logic gate,
  output logic gate_rise,
  output logic gate_fall
);
  gate_st_e st_q, st_d;

  assign gate_rise = (st_q == GS_WAIT) && count_req && sby_rise;
  assign gate_fall = (st_q == GS_HIGH) && sby_rise;
  assign gate      = (st_q == GS_HIGH);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_IDLE: if (count_req) st_d = GS_WAIT;
      GS_WAIT: begin
        if (!count_req)     st_d = GS_IDLE;
        else if (gate_rise) st_d = GS_HIGH;
      end
      GS_HIGH: if (gate_fall) st_d = GS_DONE;
      GS_DONE: if (!count_req) st_d = GS_IDLE;
      default: st_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GS_IDLE;
    else        st_q <= st_d;
  end

  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(count_req)); // R10
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GS_DONE && count_req) |=> !gate); // R9
  AST_GATE_ENDS_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> $past(sby_rise)); // R4
endmodule

// File: rtl/osc_ctrl_reg.sv
module osc_ctrl_reg
  import osc_meas_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hw_set_ready,
  output logic [FC_W-1:0]  fc,
  output logic             test,
  output logic             count,
  output logic             ready
);
  logic ready_d;
  wire  unused_rsvd = ^wr_data[6:5];

  // Software may only clear ready, and only when the stored request is off.
  always_comb begin
    ready_d = ready;
    if (wr_en) ready_d = ready & (wr_data[BIT_READY] | count);
    if (hw_set_ready) ready_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc    <= '0;
      test  <= 1'b0;
      count <= 1'b0;
      ready <= 1'b0;
    end else begin
      if (wr_en) begin
        fc    <= wr_data[FC_W-1:0];
        test  <= wr_data[BIT_TEST];
        count <= wr_data[BIT_COUNT];
      end
      ready <= ready_d;
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && count) |=> ready); // R6
  AST_HW_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set_ready |=> ready); // R5
  AST_SW_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !hw_set_ready) |=> !ready); // R7
endmodule

// File: rtl/osc_meas_ctrl.sv
module osc_meas_ctrl
  import osc_meas_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sby_clk,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       gate,
  output logic       tmr_sel,
  output logic [2:0] fc_trim
);
  logic            sby_rise;
  logic            gate_rise;
  logic            gate_fall;
  logic [FC_W-1:0] fc_q;
  logic            test_q, count_q, ready_q;

  sby_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sby_clk), .rise(sby_rise)
  );

  gate_gen u_gate (
    .clk(clk), .rst_n(rst_n), .count_req(count_q), .sby_rise(sby_rise),
    .gate(gate), .gate_rise(gate_rise), .gate_fall(gate_fall)
  );

  osc_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .hw_set_ready(gate_fall), .fc(fc_q), .test(test_q),
    .count(count_q), .ready(ready_q)
  );

  always_comb begin
    rd_data = '0;
    rd_data[FC_W-1:0] = fc_q;
    rd_data[BIT_TEST]  = test_q;
    rd_data[BIT_COUNT] = count_q;
    rd_data[BIT_READY] = ready_q;
  end

  assign tmr_sel = test_q;
  assign fc_trim = fc_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[6:5] == 2'b00); // R8
  AST_FALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> rd_data[BIT_READY]); // R5
  AST_RISE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    gate_rise |-> !gate); // R4
endmodule

// File: tb/osc_meas_ctrl_test.sv
module osc_meas_ctrl_test;
  localparam int SBY_CYC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sby_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       gate, tmr_sel;
  logic [2:0] fc_trim;

  int n_chk = 0;
  int n_fail = 0;

  osc_meas_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sby_clk(sby_clk), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .gate(gate),
    .tmr_sel(tmr_sel), .fc_trim(fc_trim)
  );

  always #2 clk = ~clk;
  always #(SBY_CYC * 2) sby_clk = ~sby_clk;

  function automatic int khz_of(input logic [2:0] c);
    case (c)
      3'd0: return 44; 3'd1: return 40; 3'd2: return 36; 3'd3: return 32;
      3'd4: return 28; 3'd5: return 24; 3'd6: return 20; default: return 16;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Waits for a pulse, returns its width (0 if none within the window).
  task automatic catch_pulse(output int width);
    width = 0;
    for (int i = 0; i < 3 * SBY_CYC && !gate; i++) @(negedge clk);
    while (gate && width < 4 * SBY_CYC) begin width++; @(negedge clk); end
  endtask

  task automatic t_reset;
    check(rd_data == 8'h00, "R1", rd_data, 0);
    check(gate == 0 && tmr_sel == 0, "R1", {gate, tmr_sel}, 0);
    check(khz_of(fc_trim) == 44, "R1", khz_of(fc_trim), 44);
  endtask

  task automatic t_regs;
    wr(8'h6B);
    check(rd_data == 8'h0B, "R8", rd_data, 8'h0B);
    check(fc_trim == 3'd3 && khz_of(fc_trim) == 32, "R2", fc_trim, 3);
    check(tmr_sel == 1, "R3", tmr_sel, 1);
    wr(8'hE5);
    check(rd_data == 8'h05, "R7", rd_data, 8'h05);
    check(khz_of(fc_trim) == 24 && tmr_sel == 0, "R2", fc_trim, 5);
    wr(8'h07);
    check(khz_of(fc_trim) == 16, "R2", khz_of(fc_trim), 16);
    wr(8'h00);
  endtask

  task automatic t_pulse(input logic [7:0] v, input string tag);
    int w;
    @(negedge sby_clk);
    wr(v);
    catch_pulse(w);
    check(w == SBY_CYC, tag, w, SBY_CYC);
    check(rd_data[7] == 1, "R5", rd_data, v | 8'h80);
    check(rd_data == (v | 8'h80), "R5", rd_data, v | 8'h80);
  endtask

  task automatic t_no_retrigger;
    int seen = 0;
    for (int i = 0; i < 3 * SBY_CYC; i++) begin
      @(negedge clk);
      if (gate) seen++;
    end
    check(seen == 0, "R9", seen, 0);
  endtask

  task automatic t_ready_hold;
    wr(8'h18);
    check(rd_data == 8'h98, "R6", rd_data, 8'h98);
    wr(8'h08);
    check(rd_data == 8'h88, "R6", rd_data, 8'h88);
    wr(8'h00);
    check(rd_data == 8'h00, "R7", rd_data, 0);
  endtask

  task automatic t_abort;
    int w;
    @(negedge sby_clk);
    wr(8'h10);
    wr(8'h00);
    catch_pulse(w);
    check(w == 0, "R10", w, 0);
    check(rd_data == 8'h00, "R10", rd_data, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_pulse(8'h18, "R4");
    t_no_retrigger;
    t_ready_hold;
    t_pulse(8'h13, "R9");
    wr(8'h13);
    check(rd_data == 8'h93, "R6", rd_data, 8'h93);
    wr(8'h00);
    wr(8'h00);
    check(rd_data == 8'h00, "R7", rd_data, 0);
    t_abort;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule